// File: doc/BRIEF.md
# Selectable-Oversampling UART Baud Rate Generator

This block produces the bit timing for a 16550-style serial port. A 16-bit divisor prescales the input clock into an oversample tick. A mode register then picks how many oversample ticks make up one bit:

- the classic 16,
- a fast 4,
- or a programmable count with a programmable sample position.

The block drives three timing strobes. The transmit side uses the bit-boundary strobe. The receive side uses the sample strobe. The oversample tick is exported for any logic that needs the finer grid.

Software reaches the block through a word-aligned 32-bit register port. Byte address = word index × 4, and only the low eight data bits are meaningful. The divisor bytes share word indices 0 and 1 with the data and interrupt-enable registers of the surrounding port. They are reached only while bit 7 of the line control register (the divisor-access bit) is set. Any write that changes timing restarts the counters, so a new setting takes effect on a clean bit.

The interface carries no data stream, so every pin is a plain control or status signal. No handshake is involved.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset, reads return these values: line control 0x00, mode 0x00, sample count 0x00, sample point 0xFF, rate-fix 0x00. The divisor resets to 0, which gives a bit period of 16 clocks.
- R2: Register byte addresses are fixed as follows, with bits [7:0] of read and write data used:
  - line control at 0x0C, where bit 7 is the divisor-access bit;
  - mode at 0x24;
  - sample count at 0x28;
  - sample point at 0x2C;
  - rate-fix at 0x34;
  - divisor low byte at 0x00 and high byte at 0x04, reachable while the divisor-access bit is 1.
- R3: While the divisor-access bit is 0, writes to 0x00 and 0x04 leave the divisor unchanged, and reads of those addresses return 0.
- R4: Mode values 0, 1 and any value above 3 select 16 oversample ticks per bit. The bit period is 16 × divisor clocks, and the sample falls on tick index 8 (the 9th tick of the bit).
- R5: Mode value 2 selects 4 ticks per bit. The bit period is 4 × divisor clocks, the sample falls on tick index 2, and the sample count register has no effect.
- R6: Mode value 3 gives a bit period of divisor × (sample count + 1) clocks. The sample falls on tick index equal to the sample point.
- R7: In mode 3, if the sample point exceeds the sample count, the sample falls on tick index (sample count + 1) / 2, rounded down.
- R8: A divisor of 0 behaves exactly as a divisor of 1.
- R9: Strobe relationships:
  - `os_tick` pulses once every divisor clocks;
  - `bit_strobe` coincides with the last tick of each bit;
  - `sample_strobe` coincides with a tick, exactly once per bit.
- R10: A write to the divisor bytes, mode, sample count or sample point restarts both counters. The first `bit_strobe` then appears in the (ticks-per-bit × divisor)-th cycle after the write edge.
- R11: The rate-fix register is readable and writable, and its value never changes any strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable, one cycle per write |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data, bits [7:0] used |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| os_tick | output | 1 | Oversample tick |
| bit_strobe | output | 1 | Last tick of each bit period |
| sample_strobe | output | 1 | Sampling tick within each bit |

## Verification
The assertions assume these conditions on the inputs:
- `reg_wr` is a one-cycle pulse at a word-aligned address;
- reset is applied before any write;
- any change of timing registers passes through a write, which restarts the counters.

The once-per-bit sample check relies on that restart. The stimulus therefore configures each case fully and measures only after the last timing write. Every corner is reached this way: a zero divisor, a sample point equal to the count, a sample point beyond it, and the unused mode values.

// File: rtl/uart_rg_pkg.sv
package uart_rg_pkg;
  // word indices (byte address >> 2)
  localparam int unsigned W_DIV_LO  = 0;
  localparam int unsigned W_DIV_HI  = 1;
  localparam int unsigned W_LINE    = 3;
  localparam int unsigned W_MODE    = 9;
  localparam int unsigned W_SCOUNT  = 10;
  localparam int unsigned W_SPOINT  = 11;
  localparam int unsigned W_RATEFIX = 13;

  localparam int unsigned ACCESS_BIT = 7;

  typedef enum logic [1:0] {
    OSR_16   = 2'd0,
    OSR_4    = 2'd1,
    OSR_PROG = 2'd2
  } osr_sel_e;

  function automatic osr_sel_e decode_mode(input logic [7:0] m);
    case (m)
      8'd2:    return OSR_4;
      8'd3:    return OSR_PROG;
      default: return OSR_16;
    endcase
  endfunction
endpackage

// File: rtl/uart_rg_regs.sv
module uart_rg_regs
  import uart_rg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [7:0]        mode_q,
  output logic [CNT_W-1:0]  scount_q,
  output logic [CNT_W-1:0]  spoint_q,
  output logic              access_q,
  output logic              resync
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [7:0]        line_q;
  logic [7:0]        ratefix_q;
  logic              hit_lo, hit_hi, hit_line, hit_mode, hit_sc, hit_sp, hit_rf;

  assign widx     = addr[ADDR_W-1:2];
  assign access_q = line_q[ACCESS_BIT];

  assign hit_lo   = wr && (widx == WIDX_W'(W_DIV_LO)) && access_q;
  assign hit_hi   = wr && (widx == WIDX_W'(W_DIV_HI)) && access_q;
  assign hit_line = wr && (widx == WIDX_W'(W_LINE));
  assign hit_mode = wr && (widx == WIDX_W'(W_MODE));
  assign hit_sc   = wr && (widx == WIDX_W'(W_SCOUNT));
  assign hit_sp   = wr && (widx == WIDX_W'(W_SPOINT));
  assign hit_rf   = wr && (widx == WIDX_W'(W_RATEFIX));

  assign resync = hit_lo | hit_hi | hit_mode | hit_sc | hit_sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      line_q    <= 8'h00;
      mode_q    <= 8'h00;
      scount_q  <= '0;
      spoint_q  <= '1;
      ratefix_q <= 8'h00;
    end else begin
      if (hit_lo)   div_q[7:0]       <= wdata[7:0];
      if (hit_hi)   div_q[DIV_W-1:8] <= wdata[DIV_W-9:0];
      if (hit_line) line_q           <= wdata[7:0];
      if (hit_mode) mode_q           <= wdata[7:0];
      if (hit_sc)   scount_q         <= wdata[CNT_W-1:0];
      if (hit_sp)   spoint_q         <= wdata[CNT_W-1:0];
      if (hit_rf)   ratefix_q        <= wdata[7:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (widx)
      WIDX_W'(W_DIV_LO):  if (access_q) rdata[7:0] = div_q[7:0];
      WIDX_W'(W_DIV_HI):  if (access_q) rdata[DIV_W-9:0] = div_q[DIV_W-1:8];
      WIDX_W'(W_LINE):    rdata[7:0] = line_q;
      WIDX_W'(W_MODE):    rdata[7:0] = mode_q;
      WIDX_W'(W_SCOUNT):  rdata[CNT_W-1:0] = scount_q;
      WIDX_W'(W_SPOINT):  rdata[CNT_W-1:0] = spoint_q;
      WIDX_W'(W_RATEFIX): rdata[7:0] = ratefix_q;
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_rg_timing.sv
module uart_rg_timing
  import uart_rg_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic [DIV_W-1:0] div_q,
  input  logic [7:0]       mode_q,
  input  logic [CNT_W-1:0] scount_q,
  input  logic [CNT_W-1:0] spoint_q,
  output logic [DIV_W-1:0] div_eff,
  output logic [CNT_W-1:0] idx_max,
  output logic [CNT_W-1:0] samp_idx
);
  osr_sel_e      sel;
  logic [CNT_W:0] half_prog;

  assign sel       = decode_mode(mode_q);
  assign div_eff   = (div_q == '0) ? DIV_W'(1) : div_q;
  assign half_prog = ({1'b0, scount_q} + (CNT_W+1)'(1)) >> 1;

  always_comb begin
    case (sel)
      OSR_4: begin
        idx_max  = CNT_W'(3);
        samp_idx = CNT_W'(2);
      end
      OSR_PROG: begin
        idx_max  = scount_q;
        samp_idx = (spoint_q <= scount_q) ? spoint_q : half_prog[CNT_W-1:0];
      end
      default: begin
        idx_max  = CNT_W'(15);
        samp_idx = CNT_W'(8);
      end
    endcase
  end
endmodule

// File: rtl/uart_rg_counter.sv
module uart_rg_counter #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic [DIV_W-1:0] div_eff,
  input  logic [CNT_W-1:0] idx_max,
  input  logic [CNT_W-1:0] samp_idx,
  output logic             os_tick,
  output logic             bit_strobe,
  output logic             sample_strobe
);
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] idx_q;
  logic             last_idx;

  assign os_tick       = (pre_q >= div_eff - DIV_W'(1));
  assign last_idx      = (idx_q >= idx_max);
  assign bit_strobe    = os_tick && last_idx;
  assign sample_strobe = os_tick && (idx_q == samp_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      idx_q <= '0;
    end else if (resync) begin
      pre_q <= '0;
      idx_q <= '0;
    end else if (os_tick) begin
      pre_q <= '0;
      idx_q <= last_idx ? '0 : idx_q + CNT_W'(1);
    end else begin
      pre_q <= pre_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              os_tick,
  output logic              bit_strobe,
  output logic              sample_strobe
);
  logic [DIV_W-1:0] div_q, div_eff;
  logic [7:0]       mode_q;
  logic [CNT_W-1:0] scount_q, spoint_q, idx_max, samp_idx;
  logic             access_q, resync;

  uart_rg_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .div_q(div_q), .mode_q(mode_q), .scount_q(scount_q),
    .spoint_q(spoint_q), .access_q(access_q), .resync(resync)
  );

  uart_rg_timing #(.DIV_W(DIV_W), .CNT_W(CNT_W)) timing_i (
    .div_q(div_q), .mode_q(mode_q), .scount_q(scount_q), .spoint_q(spoint_q),
    .div_eff(div_eff), .idx_max(idx_max), .samp_idx(samp_idx)
  );

  uart_rg_counter #(.DIV_W(DIV_W), .CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst_n(rst_n), .resync(resync), .div_eff(div_eff),
    .idx_max(idx_max), .samp_idx(samp_idx), .os_tick(os_tick),
    .bit_strobe(bit_strobe), .sample_strobe(sample_strobe)
  );
endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              access_q,
  input logic              resync,
  input logic [DIV_W-1:0]  div_q,
  input logic [DIV_W-1:0]  div_eff,
  input logic [CNT_W-1:0]  idx_max,
  input logic [CNT_W-1:0]  scount_q,
  input logic [CNT_W-1:0]  spoint_q,
  input logic              os_tick,
  input logic              bit_strobe,
  input logic              sample_strobe
);
  logic samp_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    samp_seen <= 1'b0;
    else if (resync || bit_strobe) samp_seen <= 1'b0;
    else if (sample_strobe)        samp_seen <= 1'b1;
  end

  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    !rst_n |=> (scount_q == '0 && spoint_q == '1 && div_q == '0));

  // R3
  divisor_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[ADDR_W-1:3] == '0 && !access_q) |=> $stable(div_q));

  // R9
  bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> os_tick);

  // R9
  sample_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> os_tick);

  // R9
  one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !bit_strobe) |-> !samp_seen);

  // R10
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!bit_strobe || (div_eff == DIV_W'(1) && idx_max == '0)));
endmodule

bind uart_rate_gen uart_rate_gen_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .access_q(access_q), .resync(resync), .div_q(div_q), .div_eff(div_eff),
  .idx_max(idx_max), .scount_q(scount_q), .spoint_q(spoint_q),
  .os_tick(os_tick), .bit_strobe(bit_strobe), .sample_strobe(sample_strobe)
);

// File: tb/uart_rate_gen_tb_top.sv
module uart_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // mode, divisor, scount, spoint, expected period, expected sample offset
  localparam int VEC [NV][6] = '{
    '{0, 1, 0,   255, 16, 9},
    '{0, 3, 0,   255, 48, 27},
    '{2, 2, 0,   255, 8,  6},
    '{3, 1, 9,   4,   10, 5},
    '{3, 2, 7,   0,   16, 2},
    '{3, 1, 12,  255, 13, 7},
    '{1, 2, 0,   255, 32, 18},
    '{5, 1, 0,   255, 16, 9},
    '{3, 3, 4,   4,   15, 15},
    '{0, 0, 0,   255, 16, 9},
    '{2, 1, 9,   255, 4,  3}
  };

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic os_tick, bit_strobe, sample_strobe;
  int checks = 0, errors = 0, cyc = 0;

  uart_rate_gen dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .os_tick(os_tick),
    .bit_strobe(bit_strobe), .sample_strobe(sample_strobe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R9 watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 6'(a); reg_wdata = d; reg_wr = 1;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 6'(a); #1; d = int'(reg_rdata);
  endtask

  task automatic cfg(input int m, input int dv, input int sc, input int sp);
    wr(32'h0C, 32'h80); wr(32'h00, dv & 255); wr(32'h04, dv >> 8);
    wr(32'h0C, 0); wr(32'h28, sc); wr(32'h2C, sp); wr(32'h24, m);
  endtask

  // from a bit boundary, measure period, sample offset and tick count
  task automatic measure(output int per, output int soff, output int ticks);
    per = -1; soff = -1; ticks = 0;
    for (int i = 0; i < 5000 && !bit_strobe; i++) @(negedge clk);
    for (int n = 1; n < 5000; n++) begin
      @(negedge clk);
      if (os_tick) ticks++;
      if (sample_strobe && soff < 0) soff = n;
      if (bit_strobe) begin per = n; break; end
    end
  endtask

  initial begin
    int v, p, s, t, k;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(32'h0C, v); chk("R1 line", v, 0);
    rd(32'h24, v); chk("R1 mode", v, 0);
    rd(32'h28, v); chk("R1 scount", v, 0);
    rd(32'h2C, v); chk("R1 spoint", v, 255);
    rd(32'h34, v); chk("R1 ratefix", v, 0);
    measure(p, s, t); chk("R1 reset period", p, 16);

    // vector table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      measure(p, s, t);
      chk("R4/R5/R6 period", p, VEC[i][4]);
      chk("R6/R7 sample offset", s, VEC[i][5]);
      chk("R9 ticks per bit", t, VEC[i][4] / (VEC[i][1] == 0 ? 1 : VEC[i][1]));
    end

    // R2 divisor readback with access bit set
    wr(32'h0C, 32'h80); wr(32'h00, 32'h34); wr(32'h04, 32'h12);
    rd(32'h00, v); chk("R2 div low", v, 32'h34);
    rd(32'h04, v); chk("R2 div high", v, 32'h12);
    rd(32'h0C, v); chk("R2 line", v, 32'h80);
    // R3 access bit clear: reads 0, writes ignored
    wr(32'h0C, 0);
    rd(32'h00, v); chk("R3 read low", v, 0);
    wr(32'h00, 32'h02); wr(32'h04, 32'h00);
    wr(32'h0C, 32'h80);
    rd(32'h00, v); chk("R3 low kept", v, 32'h34);
    rd(32'h04, v); chk("R3 high kept", v, 32'h12);
    // R3 timing unchanged by ignored write
    cfg(3, 2, 3, 255);
    wr(32'h0C, 0); wr(32'h00, 5);
    measure(p, s, t); chk("R3 period", p, 8);

    // R11 rate-fix has no effect
    wr(32'h34, 32'h5A);
    rd(32'h34, v); chk("R11 readback", v, 32'h5A);
    measure(p, s, t); chk("R11 period", p, 8);
    chk("R11 sample", s, 6);

    // R10 restart: first bit strobe in cycle ratio*div after the write
    cfg(0, 2, 0, 255);
    for (int i = 0; i < 7; i++) @(negedge clk);
    wr(32'h24, 0);
    k = 0;
    while (!bit_strobe && k < 1000) begin @(negedge clk); k++; end
    chk("R10 restart", k + 1, 32);
    cfg(3, 1, 0, 255);
    measure(p, s, t); chk("R10 ratio one period", p, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule